// File: doc/BRIEF.md
# Banked GPIO Register Front End

This block is the register side of a 128-pin general-purpose I/O controller. The pins are grouped into four banks of 32. A simple word-addressed bus reads and writes the registers, which sit on a sparse and irregular offset map. For each bank there is a direction word, an output latch, rising and falling edge-enable words, and two alternate-function words. The output latch is reached through separate set and clear ports, so one pin can change without a read-modify-write. A level read mixes driven and sampled values pin by pin.

The block drives each pin output from its latch bit, gated by the direction bit. It flags each pin whose presented value changes for one cycle. Each read of a level register produces a one-cycle notify pulse. Edge detection belongs to a separate block. That block supplies the edge status, and this block hands it a one-cycle clear mask when software writes to a status register.

A bus request is accepted in the cycle where `req_valid` is high at a rising clock edge. Read data, the error flag and the level-read pulse all appear registered one cycle later.

Top module: `gpio_bank_regs`

## Requirements
- R1: Level registers for banks 0, 1 and 2 are at offsets 0x000, 0x004 and 0x008, and bank 3's is at 0x100. Direction registers are at 0x00C, 0x010, 0x014 and 0x10C. Set registers are at 0x018, 0x01C, 0x020 and 0x118. Clear registers are at 0x024, 0x028, 0x02C and 0x124. Direction reads back as written, and a direction bit of 1 makes that pin an output.
- R2: Rising-enable registers are at 0x030, 0x034, 0x038 and 0x130. Falling-enable registers are at 0x03C, 0x040, 0x044 and 0x13C. Both read back as written and drive `rise_en` and `fall_en`. Bank n occupies bits [32n+31:32n] of every 128-bit pin vector.
- R3: A request at offset 0x200 or above reads as zero, does not raise `rsp_err`, and a write there changes nothing.
- R4: A write to a set register ORs the data into that bank's output latch. A write to a clear register clears the latch bits where the data is 1. Both registers read as zero without an error.
- R5: A level read returns, for each bit, the latch value where the direction bit is 1 and the `pin_in` value where it is 0.
- R6: `lvl_rd_pulse` is high for exactly the one cycle in which the response to a level read is presented, and for no other access.
- R7: `pin_out` equals the output latch ANDed with the direction bit, so an input pin drives 0.
- R8: `pin_chg` is high for one cycle on exactly the bits whose `pin_out` value has just changed. A bit that is rewritten with the same value does not pulse.
- R9: The lower alternate-function word of bank n is at 0x054+8n and the upper word is at 0x058+8n. Both are plain read/write storage. They appear on `alt_func`, with lower word n at bits [64n+31:64n] and upper word n at bits [64n+63:64n+32].
- R10: An offset below 0x200 that is unmapped or not word-aligned reads as zero and raises `rsp_err` for one cycle. A write to such an offset changes nothing but raises `rsp_err` in the same way.
- R11: Edge-status registers are at 0x048, 0x04C, 0x050 and 0x148. A read returns that bank's slice of `edge_sts`. A write drives the written word onto that bank's slice of `edge_clr` for exactly one cycle, and every other bit of `edge_clr` stays 0.
- R12: After reset, direction, the output latches, the enables, the alternate-function words and all outputs are zero.
- R13: Read data is presented with `rsp_valid` in the cycle after the request. Writes to a level register are ignored and raise no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_rdata | output | 32 | Read data |
| rsp_err | output | 1 | One-cycle pulse for an unmapped in-range access |
| lvl_rd_pulse | output | 1 | One-cycle pulse when a level read responds |
| pin_in | input | 128 | Sampled pin levels |
| pin_out | output | 128 | Driven pin values (latch AND direction) |
| pin_chg | output | 128 | One-cycle per-pin change flags |
| rise_en | output | 128 | Rising-edge enables to the edge block |
| fall_en | output | 128 | Falling-edge enables to the edge block |
| alt_func | output | 256 | Alternate-function words |
| edge_sts | input | 128 | Edge status from the edge block |
| edge_clr | output | 128 | One-cycle clear mask to the edge block |

## Verification
Some properties are checked on every cycle by the assertions:
- A set write leaves every written bit high in the latch, and a clear write leaves every written bit low.
- Set, clear and high-offset reads return zero.
- An error response carries zero data.
- The level-read pulse occurs only together with a response.
- `pin_out` changes only in the cycle after a write.

Other behaviour can only be shown by the bench's scenarios:
- The exact placement of each register in the irregular map, including bank 3 above 0x100 and the interleaved alternate-function words.
- The mixed level read-back.
- The one-cycle width of `pin_chg` and `edge_clr`.
- Aliasing above 0x200 leaving state untouched.

// File: rtl/gpio_regs_pkg.sv
package gpio_regs_pkg;
  localparam int NBANK = 4;

  typedef enum logic [3:0] {
    K_NONE, K_LVL, K_DIR, K_SET, K_CLR, K_RISE, K_FALL, K_STS,
    K_ALT_LO, K_ALT_HI, K_OOR
  } reg_kind_e;
endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_regs_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_kind_e         kind,
  output logic [1:0]        bank
);
  logic [5:0] idx;
  logic [5:0] grp;
  logic [1:0] rem;
  logic [2:0] aoff;

  function automatic reg_kind_e grp_kind(input logic [5:0] g);
    case (g)
      6'd0:    return K_LVL;
      6'd1:    return K_DIR;
      6'd2:    return K_SET;
      6'd3:    return K_CLR;
      6'd4:    return K_RISE;
      6'd5:    return K_FALL;
      6'd6:    return K_STS;
      default: return K_NONE;
    endcase
  endfunction

  always_comb begin
    idx  = addr[7:2];
    grp  = idx / 6'd3;
    rem  = 2'(idx % 6'd3);
    aoff = 3'(idx - 6'd21);
    kind = K_NONE;
    bank = 2'd0;
    if (addr[ADDR_W-1:9] != '0) begin
      kind = K_OOR;
    end else if (addr[1:0] == 2'b00) begin
      if (addr[8]) begin
        // upper window holds bank 3 only, one word per register group
        if (rem == 2'd0) begin
          kind = grp_kind(grp);
          bank = 2'd3;
        end
      end else if (idx < 6'd21) begin
        kind = grp_kind(grp);
        bank = rem;
      end else if (idx <= 6'd28) begin
        kind = aoff[0] ? K_ALT_HI : K_ALT_LO;
        bank = aoff[2:1];
      end
    end
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank #(
  parameter int BANK_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BANK_W-1:0] wdata,
  input  logic              we_dir,
  input  logic              we_set,
  input  logic              we_clr,
  input  logic              we_rise,
  input  logic              we_fall,
  input  logic              we_alo,
  input  logic              we_ahi,
  output logic [BANK_W-1:0] dir_q,
  output logic [BANK_W-1:0] olat_q,
  output logic [BANK_W-1:0] rise_q,
  output logic [BANK_W-1:0] fall_q,
  output logic [BANK_W-1:0] alo_q,
  output logic [BANK_W-1:0] ahi_q,
  output logic [BANK_W-1:0] pin_out,
  output logic [BANK_W-1:0] pin_chg
);
  logic [BANK_W-1:0] dir_d, olat_d, rise_d, fall_d, alo_d, ahi_d;
  logic [BANK_W-1:0] shown_q;

  always_comb begin
    dir_d  = we_dir  ? wdata : dir_q;
    rise_d = we_rise ? wdata : rise_q;
    fall_d = we_fall ? wdata : fall_q;
    alo_d  = we_alo  ? wdata : alo_q;
    ahi_d  = we_ahi  ? wdata : ahi_q;
    olat_d = olat_q;
    if (we_set) olat_d = olat_d | wdata;
    if (we_clr) olat_d = olat_d & ~wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= '0;
      olat_q  <= '0;
      rise_q  <= '0;
      fall_q  <= '0;
      alo_q   <= '0;
      ahi_q   <= '0;
      shown_q <= '0;
    end else begin
      dir_q   <= dir_d;
      olat_q  <= olat_d;
      rise_q  <= rise_d;
      fall_q  <= fall_d;
      alo_q   <= alo_d;
      ahi_q   <= ahi_d;
      shown_q <= pin_out;
    end
  end

  assign pin_out = olat_q & dir_q;
  assign pin_chg = pin_out ^ shown_q;

  // R4: set leaves written bits high, clear leaves them low
  a_r4_set_or: assert property (@(posedge clk) disable iff (!rst_n)
    (we_set && !we_clr) |=> ((olat_q & $past(wdata)) == $past(wdata)));
  a_r4_clr_andn: assert property (@(posedge clk) disable iff (!rst_n)
    (we_clr && !we_set) |=> ((olat_q & $past(wdata)) == '0));
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_regs_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int BANK_W = 32,
  localparam int NPIN = NBANK * BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BANK_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [BANK_W-1:0] rsp_rdata,
  output logic              rsp_err,
  output logic              lvl_rd_pulse,
  input  logic [NPIN-1:0]   pin_in,
  output logic [NPIN-1:0]   pin_out,
  output logic [NPIN-1:0]   pin_chg,
  output logic [NPIN-1:0]   rise_en,
  output logic [NPIN-1:0]   fall_en,
  output logic [2*NPIN-1:0] alt_func,
  input  logic [NPIN-1:0]   edge_sts,
  output logic [NPIN-1:0]   edge_clr
);
  reg_kind_e d_kind;
  logic [1:0] d_bank;
  logic wr, rd;
  logic [BANK_W-1:0] dir_a [NBANK];
  logic [BANK_W-1:0] olat_a [NBANK];
  logic [BANK_W-1:0] rise_a [NBANK];
  logic [BANK_W-1:0] fall_a [NBANK];
  logic [BANK_W-1:0] alo_a [NBANK];
  logic [BANK_W-1:0] ahi_a [NBANK];
  logic [BANK_W-1:0] rd_mux, pin_sl, sts_sl;
  logic [NPIN-1:0] clr_d;
  logic rsp_valid_d, rsp_err_d, lvl_d;
  logic [BANK_W-1:0] rsp_rdata_d;

  assign wr = req_valid &&  req_write;
  assign rd = req_valid && !req_write;

  gpio_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(req_addr), .kind(d_kind), .bank(d_bank)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic hit;
    assign hit = wr && (d_bank == 2'(b));
    gpio_bank #(.BANK_W(BANK_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .wdata(req_wdata),
      .we_dir (hit && d_kind == K_DIR),
      .we_set (hit && d_kind == K_SET),
      .we_clr (hit && d_kind == K_CLR),
      .we_rise(hit && d_kind == K_RISE),
      .we_fall(hit && d_kind == K_FALL),
      .we_alo (hit && d_kind == K_ALT_LO),
      .we_ahi (hit && d_kind == K_ALT_HI),
      .dir_q(dir_a[b]), .olat_q(olat_a[b]), .rise_q(rise_a[b]),
      .fall_q(fall_a[b]), .alo_q(alo_a[b]), .ahi_q(ahi_a[b]),
      .pin_out(pin_out[b*BANK_W +: BANK_W]),
      .pin_chg(pin_chg[b*BANK_W +: BANK_W])
    );
    assign rise_en[b*BANK_W +: BANK_W] = rise_a[b];
    assign fall_en[b*BANK_W +: BANK_W] = fall_a[b];
    assign alt_func[2*b*BANK_W +: BANK_W]     = alo_a[b];
    assign alt_func[(2*b+1)*BANK_W +: BANK_W] = ahi_a[b];
    assign clr_d[b*BANK_W +: BANK_W] = (hit && d_kind == K_STS) ? req_wdata : '0;
  end

  // read data selection and response next-state
  always_comb begin
    pin_sl = pin_in[int'(d_bank)*BANK_W +: BANK_W];
    sts_sl = edge_sts[int'(d_bank)*BANK_W +: BANK_W];
    case (d_kind)
      K_LVL:    rd_mux = (olat_a[d_bank] & dir_a[d_bank]) | (pin_sl & ~dir_a[d_bank]);
      K_DIR:    rd_mux = dir_a[d_bank];
      K_RISE:   rd_mux = rise_a[d_bank];
      K_FALL:   rd_mux = fall_a[d_bank];
      K_STS:    rd_mux = sts_sl;
      K_ALT_LO: rd_mux = alo_a[d_bank];
      K_ALT_HI: rd_mux = ahi_a[d_bank];
      default:  rd_mux = '0;
    endcase
    rsp_valid_d = rd;
    rsp_err_d   = req_valid && d_kind == K_NONE;
    lvl_d       = rd && d_kind == K_LVL;
    rsp_rdata_d = rd ? rd_mux : rsp_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_err      <= 1'b0;
      lvl_rd_pulse <= 1'b0;
      rsp_rdata    <= '0;
      edge_clr     <= '0;
    end else begin
      rsp_valid    <= rsp_valid_d;
      rsp_err      <= rsp_err_d;
      lvl_rd_pulse <= lvl_d;
      rsp_rdata    <= rsp_rdata_d;
      edge_clr     <= clr_d;
    end
  end

  // R3: high offsets read zero with no error
  a_r3_oor_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && req_addr[ADDR_W-1:9] != '0) |=> (rsp_rdata == '0 && !rsp_err));
  // R4: set/clear ports read as zero
  a_r4_wo_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && (d_kind == K_SET || d_kind == K_CLR)) |=> (rsp_rdata == '0));
  // R10: error responses carry zero data
  a_r10_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_err && rsp_valid) |-> (rsp_rdata == '0));
  // R6: notify only accompanies a read response
  a_r6_notify_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_rd_pulse |-> rsp_valid);
  // R8: driven pins move only after a write
  a_r8_chg_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out != $past(pin_out)) |-> $past(wr));
endmodule

// File: tb/gpio_bank_regs_test.sv
`timescale 1ns/1ps
module gpio_bank_regs_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic rsp_valid, rsp_err, lvl_rd_pulse;
  logic [31:0] rsp_rdata;
  logic [127:0] pin_in = '0, edge_sts = '0;
  logic [127:0] pin_out, pin_chg, rise_en, fall_en, edge_clr;
  logic [255:0] alt_func;
  int tests = 0, fails = 0;
  bit done = 0;

  typedef struct { logic [31:0] data; logic err; logic lvl; string tag; } exp_t;
  exp_t sb_q[$];

  always #2.5 clk = ~clk;

  gpio_bank_regs uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .lvl_rd_pulse(lvl_rd_pulse),
    .pin_in(pin_in), .pin_out(pin_out), .pin_chg(pin_chg), .rise_en(rise_en),
    .fall_en(fall_en), .alt_func(alt_func), .edge_sts(edge_sts), .edge_clr(edge_clr)
  );

  task automatic chk(string tag, logic [255:0] act, logic [255:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops scoreboard on each read response
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (sb_q.size() == 0) begin
        chk("R13 unexpected response", 1, 0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        chk(e.tag, {rsp_rdata, rsp_err, lvl_rd_pulse}, {e.data, e.err, e.lvl});
      end
    end else if (rst_n && lvl_rd_pulse) begin
      chk("R6 pulse without response", 1, 0);
    end
  end

  task automatic bus_rd(logic [11:0] a, logic [31:0] exp, logic eerr, logic elvl, string tag);
    exp_t e;
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a;
    e.data = exp; e.err = eerr; e.lvl = elvl; e.tag = tag;
    sb_q.push_back(e);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic bus_wr(logic [11:0] a, logic [31:0] d, logic eerr, string tag);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
    chk(tag, rsp_err, eerr);
  endtask

  initial begin
    logic [255:0] alt_exp;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 pin_out", pin_out, 0);
    chk("R12 enables", {rise_en, fall_en}, 0);
    chk("R12 alt", alt_func, 0);
    chk("R12 flags", {rsp_valid, rsp_err, lvl_rd_pulse, edge_clr}, 0);
    rst_n = 1;
    @(negedge clk);

    // R1/R4/R7/R8 bank 0
    bus_wr(12'h00C, 32'h0000_FFFF, 0, "R1 dir wr err");
    chk("R7 dir only", pin_out[31:0], 0);
    bus_wr(12'h018, 32'hFF00_FF00, 0, "R4 set wr err");
    chk("R7 gated out", pin_out[31:0], 32'h0000_FF00);
    chk("R8 chg pulse", pin_chg, {96'h0, 32'h0000_FF00});
    @(negedge clk);
    chk("R8 chg one cycle", pin_chg, 0);
    bus_rd(12'h00C, 32'h0000_FFFF, 0, 0, "R1 dir readback");
    bus_rd(12'h018, 32'h0, 0, 0, "R4 set reads zero");
    bus_rd(12'h024, 32'h0, 0, 0, "R4 clr reads zero");
    pin_in[31:0] = 32'hA5A5_5A5A;
    bus_rd(12'h000, 32'hA5A5_FF00, 0, 1, "R5 R6 level mix");
    bus_wr(12'h024, 32'h0000_F000, 0, "R4 clr wr err");
    chk("R4 clr effect", pin_out[31:0], 32'h0000_0F00);
    chk("R8 chg clr", pin_chg[31:0], 32'h0000_F000);
    bus_wr(12'h018, 32'h0000_0F00, 0, "R4 reset same bits");
    chk("R8 no chg same value", pin_chg, 0);

    // bank 3 in upper window, bank 2 untouched
    bus_wr(12'h10C, 32'hFFFF_FFFF, 0, "R1 b3 dir");
    bus_wr(12'h118, 32'h1234_5678, 0, "R1 b3 set");
    chk("R1 b3 pins", pin_out[127:96], 32'h1234_5678);
    chk("R1 b1 b2 untouched", pin_out[95:32], 0);
    bus_rd(12'h100, 32'h1234_5678, 0, 1, "R1 R5 b3 level");
    bus_wr(12'h124, 32'h0000_0078, 0, "R1 b3 clr");
    chk("R1 b3 clr pins", pin_out[127:96], 32'h1234_5600);

    // R2 enables
    bus_wr(12'h130, 32'hDEAD_BEEF, 0, "R2 rise wr");
    bus_wr(12'h040, 32'hCAFE_F00D, 0, "R2 fall wr");
    chk("R2 rise_en slice", rise_en, {32'hDEAD_BEEF, 96'h0});
    chk("R2 fall_en slice", fall_en, {64'h0, 32'hCAFE_F00D, 32'h0});
    bus_rd(12'h130, 32'hDEAD_BEEF, 0, 0, "R2 rise read");
    bus_rd(12'h040, 32'hCAFE_F00D, 0, 0, "R2 fall read");
    bus_rd(12'h034, 32'h0, 0, 0, "R2 rise b1 zero");

    // R9 alternate function
    alt_exp = '0;
    for (int n = 0; n < 4; n++) begin
      bus_wr(12'(12'h054 + 8*n), 32'hA000_0000 | n, 0, "R9 alt lo wr");
      bus_wr(12'(12'h058 + 8*n), 32'hB000_0000 | n, 0, "R9 alt hi wr");
      alt_exp[64*n +: 32]      = 32'hA000_0000 | n;
      alt_exp[64*n+32 +: 32]   = 32'hB000_0000 | n;
    end
    chk("R9 alt layout", alt_func, alt_exp);
    for (int n = 0; n < 4; n++) begin
      bus_rd(12'(12'h054 + 8*n), 32'hA000_0000 | n, 0, 0, "R9 alt lo read");
      bus_rd(12'(12'h058 + 8*n), 32'hB000_0000 | n, 0, 0, "R9 alt hi read");
    end

    // R11 edge status
    edge_sts = {32'h0, 32'h0, 32'h1111_2222, 32'h0};
    bus_rd(12'h04C, 32'h1111_2222, 0, 0, "R11 sts read");
    bus_wr(12'h148, 32'h0000_000F, 0, "R11 sts wr");
    chk("R11 clr pulse", edge_clr, {32'h0000_000F, 96'h0});
    @(negedge clk);
    chk("R11 clr one cycle", edge_clr, 0);

    // R10 unmapped / unaligned
    bus_rd(12'h074, 32'h0, 1, 0, "R10 gap read");
    bus_rd(12'h104, 32'h0, 1, 0, "R10 upper gap read");
    bus_rd(12'h002, 32'h0, 1, 0, "R10 unaligned read");
    bus_wr(12'h0FC, 32'hFFFF_FFFF, 1, "R10 gap write err");
    chk("R10 gap write no effect", {pin_out, rise_en, fall_en}, {32'h1234_5600, 64'h0, 32'h0000_0F00, 32'hDEAD_BEEF, 96'h0, 64'h0, 32'hCAFE_F00D, 32'h0});

    // R3 above window
    bus_rd(12'h204, 32'h0, 0, 0, "R3 high read");
    bus_wr(12'h20C, 32'h0, 0, "R3 high write err");
    bus_wr(12'h224, 32'hFFFF_FFFF, 0, "R3 high write err2");
    chk("R3 high write ignored", pin_out[31:0], 32'h0000_0F00);
    bus_rd(12'h00C, 32'h0000_FFFF, 0, 0, "R3 dir unchanged");

    // R13 level write ignored
    bus_wr(12'h000, 32'hFFFF_FFFF, 0, "R13 level write err");
    chk("R13 level write ignored", pin_out[31:0], 32'h0000_0F00);

    // R7 R8 direction to input
    bus_wr(12'h00C, 32'h0, 0, "R7 dir clear");
    chk("R7 input drives zero", pin_out[31:0], 0);
    chk("R8 chg on dir", pin_chg[31:0], 32'h0000_0F00);
    bus_rd(12'h000, 32'hA5A5_5A5A, 0, 1, "R5 all input level");

    repeat (3) @(negedge clk);
    chk("R13 scoreboard drained", sb_q.size(), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule